// File: doc/BRIEF.md
# Serial configuration memory readout

This block is the read side of a serial configuration memory. It holds a byte-wide storage array and streams that array out one bit per clock to a device being configured. Bits leave the array starting at byte 0, with the most significant bit of each byte first. A bit counter walks through each byte and an address counter walks through the bytes. An active-low chip enable, an active-high output enable and a serial-mode select decide when the counters advance and when the data output is driven.

When the last bit of the array has been shifted out, the block stops. It then pulls its active-low cascade-enable output low, so that a second memory wired behind it takes over the stream on the very next clock. Output enable low acts as a synchronous restart: the counters and the end state are cleared. The cascade output is then held high until the array has been read through once more.

A parallel load port fills the array while the block is in programming mode (serial-mode select low). Test benches and bring-up logic use this port to place a bitstream in the array.

Top module: `cfg_stream_mem`

## Requirements
- R1: When `ser_mode`=1, `ce_n`=0, `oe`=1 and the end state is not reached, `dout_en`=1 and `dout` is bit (7−b) of byte a, where b is the bit count and a is the byte address. Each rising clock edge increments b. When b wraps from 7 to 0, a increments.
- R2: While `ce_n`=1, `dout_en`=0 and both counters hold. After `ce_n` returns low, the stream resumes at the bit that was next before the pause.
- R3: `oe`=0 at a rising edge clears both counters and the end state, so that the next stream starts at bit 7 of byte 0. While `oe`=0, `dout_en`=0 and `ceo_n`=1.
- R4: The edge that consumes bit 0 of byte DEPTH−1 enters the end state. From then on, `dout_en`=0 and no further bit is read until `oe` restarts the block.
- R5: `ceo_n`=0 exactly when the end state holds, `ce_n`=0, `oe`=1 and `ser_mode`=1. Before the end state, `ceo_n`=1.
- R6: In the end state with `oe`=1, `ceo_n` follows `ce_n` in the same cycle.
- R7: After `oe` has been low, `ceo_n` stays high until the whole array has been read again.
- R8: With `ser_mode`=0, `dout_en`=0 and the counters hold, whatever `ce_n` does. In that mode, a rising edge with `ld_we`=1 writes `ld_data` to byte `ld_addr`. With `ser_mode`=1, `ld_we` has no effect.
- R9: When two blocks are chained, with the first `ceo_n` driving the second `ce_n`, the combined stream equals array 0 followed by array 1. There is no gap and no cycle in which both drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge |
| ce_n | input | 1 | Chip enable, active low |
| oe | input | 1 | Output enable; low restarts the block |
| ser_mode | input | 1 | 1 = serial read mode, 0 = programming mode |
| ld_we | input | 1 | Load port write strobe |
| ld_addr | input | $clog2(DEPTH) | Load port byte address |
| ld_data | input | W | Load port byte value |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | Serial data is valid and driven |
| ceo_n | output | 1 | Cascade enable to the next memory, active low |

## Verification
Two events meet in one cycle at the cascade handoff. On the edge that consumes the first memory's last bit, that memory stops driving. In the same cycle its cascade output falls, which enables the second memory to present its first bit. The bench provokes this by streaming a two-device chain end to end, once uninterrupted and once after a restart. A scoreboard queue holds the expected concatenation. Any cycle with both drive flags high, any missing bit and any extra bit is a miscompare.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  // Position inside a byte that the bit counter value selects (MSB first).
  function automatic int unsigned msb_index(input int unsigned count,
                                            input int unsigned width);
    return width - 1 - count;
  endfunction

  // True when a counter value is the top value of a range of lim entries.
  function automatic logic at_top(input int unsigned value,
                                  input int unsigned lim);
    return value == lim - 1;
  endfunction

endpackage

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [BW-1:0] rd_bit,
  output logic          bit_o
);
  import cfgmem_pkg::*;

  logic [W-1:0] store [DEPTH];
  logic [W-1:0] rd_byte;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_byte = store[rd_addr];
  assign bit_o   = rd_byte[BW'(msb_index(int'(rd_bit), W))];
endmodule

// File: rtl/cfgmem_counter.sv
module cfgmem_counter #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          oe,
  input  logic          adv,
  output logic [AW-1:0] addr_q,
  output logic [BW-1:0] bit_q,
  output logic          eom_q,
  output logic          wrap_evt,
  output logic          last_evt
);
  import cfgmem_pkg::*;

  logic bit_top, addr_top;

  assign bit_top  = at_top(int'(bit_q), W);
  assign addr_top = at_top(int'(addr_q), DEPTH);
  assign wrap_evt = adv && bit_top && !addr_top;
  assign last_evt = adv && bit_top && addr_top;

  always_ff @(posedge clk) begin
    if (!oe) begin
      addr_q <= '0;
      bit_q  <= '0;
      eom_q  <= 1'b0;
    end else if (last_evt) begin
      eom_q  <= 1'b1;
    end else if (wrap_evt) begin
      bit_q  <= '0;
      addr_q <= addr_q + AW'(1);
    end else if (adv) begin
      bit_q  <= bit_q + BW'(1);
    end
  end
endmodule

// File: rtl/cfgmem_cascade.sv
module cfgmem_cascade (
  input  logic ce_n,
  input  logic oe,
  input  logic ser_mode,
  input  logic eom,
  output logic selected,
  output logic drive,
  output logic ceo_n
);
  assign selected = ser_mode && !ce_n && oe;
  assign drive    = selected && !eom;
  assign ceo_n    = !(selected && eom);
endmodule

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          oe,
  input  logic          ser_mode,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  output logic          dout,
  output logic          dout_en,
  output logic          ceo_n
);
  logic          load_ok;
  logic          selected;
  logic          adv;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;
  logic          eom_q;
  logic          wrap_evt;
  logic          last_evt;

  assign load_ok = ld_we && !ser_mode;
  assign adv     = dout_en;

  cfgmem_array #(.DEPTH(DEPTH), .W(W)) u_array (
    .clk     (clk),
    .wr_en   (load_ok),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (addr_q),
    .rd_bit  (bit_q),
    .bit_o   (dout)
  );

  cfgmem_counter #(.DEPTH(DEPTH), .W(W)) u_counter (
    .clk      (clk),
    .oe       (oe),
    .adv      (adv),
    .addr_q   (addr_q),
    .bit_q    (bit_q),
    .eom_q    (eom_q),
    .wrap_evt (wrap_evt),
    .last_evt (last_evt)
  );

  cfgmem_cascade u_cascade (
    .ce_n     (ce_n),
    .oe       (oe),
    .ser_mode (ser_mode),
    .eom      (eom_q),
    .selected (selected),
    .drive    (dout_en),
    .ceo_n    (ceo_n)
  );
endmodule

// File: rtl/cfgmem_checker.sv
module cfgmem_checker #(
  parameter int AW = 8,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          ce_n,
  input logic          oe,
  input logic          ser_mode,
  input logic          dout_en,
  input logic          ceo_n,
  input logic [AW-1:0] addr_q,
  input logic [BW-1:0] bit_q,
  input logic          eom_q,
  input logic          wrap_evt,
  input logic          last_evt
);
  // R1: a plain advance moves only the bit counter
  a_r1_step: assert property (@(posedge clk) disable iff (!oe)
    (dout_en && !wrap_evt && !last_evt) |=>
      (bit_q == $past(bit_q) + BW'(1)) && $stable(addr_q));

  // R1: a wrap clears the bit counter and moves to the next byte
  a_r1_wrap: assert property (@(posedge clk) disable iff (!oe)
    wrap_evt |=> (bit_q == '0) && (addr_q == $past(addr_q) + AW'(1)));

  // R2 and R8: no advance without selection
  a_r2_frozen: assert property (@(posedge clk) disable iff (!oe)
    (ce_n || !ser_mode) |=> $stable(addr_q) && $stable(bit_q) && $stable(eom_q));

  // R3: output enable low restarts everything
  a_r3_restart: assert property (@(posedge clk)
    (oe === 1'b0) |=> (addr_q == '0) && (bit_q == '0) && !eom_q);

  // R4: the end state is sticky and silent
  a_r4_hold: assert property (@(posedge clk) disable iff (!oe)
    eom_q |=> eom_q && !dout_en);

  // R4: the last bit enters the end state
  a_r4_enter: assert property (@(posedge clk) disable iff (!oe)
    last_evt |=> eom_q);

  // R5 and R7: no cascade enable before the end
  a_r5_early: assert property (@(posedge clk) disable iff (!oe)
    !eom_q |-> ceo_n);

  // R6: in the end state the cascade output tracks chip enable
  a_r6_follow: assert property (@(posedge clk) disable iff (!oe || !ser_mode)
    eom_q |-> (ceo_n == ce_n));

  // R3 and R8: immediate checks on the drive flags
  always_comb begin
    if (oe === 1'b0) a_r3_quiet: assert (ceo_n && !dout_en);
    if (ser_mode === 1'b0) a_r8_silent: assert (!dout_en);
  end
endmodule

bind cfg_stream_mem cfgmem_checker #(.AW(AW), .BW(BW)) u_checker (
  .clk      (clk),
  .ce_n     (ce_n),
  .oe       (oe),
  .ser_mode (ser_mode),
  .dout_en  (dout_en),
  .ceo_n    (ceo_n),
  .addr_q   (addr_q),
  .bit_q    (bit_q),
  .eom_q    (eom_q),
  .wrap_evt (wrap_evt),
  .last_evt (last_evt)
);

// File: tb/test_cfg_stream_mem.sv
`timescale 1ns/1ps
module test_cfg_stream_mem;
  localparam int DEPTH = 256;
  localparam int W     = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int NBITS = DEPTH * W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          ce0_n, oe, ser_mode;
  logic          we0, we1;
  logic [AW-1:0] la0, la1;
  logic [W-1:0]  ld0, ld1;
  logic          d0, en0, ceo0_n;
  logic          d1, en1, ceo1_n;

  int vectors = 0;
  int miscompares = 0;
  bit exp_q[$];

  cfg_stream_mem #(.DEPTH(DEPTH), .W(W)) i_cfg_stream_mem (
    .clk(clk), .ce_n(ce0_n), .oe(oe), .ser_mode(ser_mode),
    .ld_we(we0), .ld_addr(la0), .ld_data(ld0),
    .dout(d0), .dout_en(en0), .ceo_n(ceo0_n));

  cfg_stream_mem #(.DEPTH(DEPTH), .W(W)) i_cfg_stream_mem_nxt (
    .clk(clk), .ce_n(ceo0_n), .oe(oe), .ser_mode(ser_mode),
    .ld_we(we1), .ld_addr(la1), .ld_data(ld1),
    .dout(d1), .dout_en(en1), .ceo_n(ceo1_n));

  function automatic logic [W-1:0] pattern(input int dev, input int a);
    int v;
    v = (a * 29 + dev * 113 + 90) ^ (a >> 3);
    return W'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R1: MSB-first order, byte by byte
  task automatic push_dev(input int dev, input int n);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] b;
      b = pattern(dev, i / W);
      exp_q.push_back(b[W - 1 - (i % W)]);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // Scoreboard monitor (R9 handoff, R4 no extra bits)
  always @(negedge clk) begin
    if (en0 === 1'b1 || en1 === 1'b1) begin
      if (en0 === 1'b1 && en1 === 1'b1)
        check(1'b0, "R9 both drive", 2, 1);
      else if (exp_q.size() == 0)
        check(1'b0, "R4 extra bit", 1, 0);
      else begin
        bit e;
        bit got;
        e = exp_q.pop_front();
        got = (en0 === 1'b1) ? d0 : d1;
        check(got == e, "R1 R9 stream bit", int'(got), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    ce0_n = 1'b0; oe = 1'b0; ser_mode = 1'b0;
    we0 = 1'b0; we1 = 1'b0; la0 = '0; la1 = '0; ld0 = '0; ld1 = '0;
    repeat (3) @(posedge clk);

    // R8: load both arrays in programming mode
    for (int a = 0; a < DEPTH; a++) begin
      #1;
      we0 = 1'b1; we1 = 1'b1;
      la0 = AW'(a); la1 = AW'(a);
      ld0 = pattern(0, a); ld1 = pattern(1, a);
      @(posedge clk);
    end
    #1; we0 = 1'b0; we1 = 1'b0;

    @(negedge clk);
    check(en0 == 1'b0, "R3 reset dout_en", int'(en0), 0);
    check(ceo0_n == 1'b1, "R3 reset ceo_n", int'(ceo0_n), 1);

    // R8: programming mode, chip enable low, counters must not move
    @(posedge clk); #1; oe = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(en0 == 1'b0, "R8 no drive dev0", int'(en0), 0);
    check(en1 == 1'b0, "R8 no drive dev1", int'(en1), 0);
    check(ceo0_n == 1'b1, "R8 ceo_n high", int'(ceo0_n), 1);

    // R8: a write in serial mode is ignored (seen later in the stream)
    @(posedge clk); #1; oe = 1'b0; ser_mode = 1'b1;
    we0 = 1'b1; la0 = '0; ld0 = ~pattern(0, 0);
    @(posedge clk); #1; we0 = 1'b0;

    // R3: partial read, then restart
    push_dev(0, 20);
    oe = 1'b1;
    repeat (20) @(posedge clk);
    #1; oe = 1'b0;
    @(negedge clk);
    check(en0 == 1'b0, "R3 oe low stops drive", int'(en0), 0);
    check(exp_q.size() == 0, "R3 partial read length", exp_q.size(), 0);

    // Full chain with a pause (R2, R9)
    @(posedge clk); #1;
    push_dev(0, NBITS); push_dev(1, NBITS);
    oe = 1'b1;
    repeat (300) @(posedge clk);
    #1; ce0_n = 1'b1;
    @(negedge clk);
    check(en0 == 1'b0 && en1 == 1'b0, "R2 paused no drive", int'(en0 | en1), 0);
    check(ceo0_n == 1'b1, "R5 ceo_n high before end", int'(ceo0_n), 1);
    repeat (5) @(posedge clk);
    #1; ce0_n = 1'b0;

    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(en0 == 1'b0 && en1 == 1'b0, "R4 end no drive", int'(en0 | en1), 0);
    check(ceo0_n == 1'b0, "R5 ceo_n low dev0", int'(ceo0_n), 0);
    check(ceo1_n == 1'b0, "R5 ceo_n low dev1", int'(ceo1_n), 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(ceo0_n == 1'b0, "R4 end state holds", int'(ceo0_n), 0);

    // R6: follow chip enable
    @(posedge clk); #1; ce0_n = 1'b1;
    @(negedge clk);
    check(ceo0_n == 1'b1, "R6 follows ce_n high", int'(ceo0_n), 1);
    check(ceo1_n == 1'b1, "R6 chained follows", int'(ceo1_n), 1);
    @(posedge clk); #1; ce0_n = 1'b0;
    @(negedge clk);
    check(ceo0_n == 1'b0, "R6 follows ce_n low", int'(ceo0_n), 0);

    // R7: restart, cascade high until a full re-read
    @(posedge clk); #1; oe = 1'b0;
    @(negedge clk);
    check(ceo0_n == 1'b1, "R7 oe low forces ceo_n", int'(ceo0_n), 1);
    @(posedge clk); #1;
    push_dev(0, NBITS); push_dev(1, NBITS);
    oe = 1'b1;
    @(negedge clk);
    check(ceo0_n == 1'b1, "R7 high after restart", int'(ceo0_n), 1);
    repeat (1000) @(posedge clk);
    @(negedge clk);
    check(ceo0_n == 1'b1, "R7 high mid re-read", int'(ceo0_n), 1);
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check(ceo0_n == 1'b0, "R7 low after re-read", int'(ceo0_n), 0);
    check(en0 == 1'b0 && en1 == 1'b0, "R9 chain finished", int'(en0 | en1), 0);

    summary();
    $finish;
  end
endmodule